// File: doc/BRIEF.md
# RMII Dibit Adapter

This block sits between a MAC that moves whole bytes and a reduced-pin Ethernet PHY that moves two bits per clock. Transmit and receive both run from one 50 MHz reference clock. Data is launched and sampled on the rising edge only, and just two data bits cross the pins in each direction.

On transmit, a byte taken over a valid/ready handshake is sent as four dibits, least significant pair first. The enable line stays high while the pins carry frame data. Bytes offered back to back leave no idle cycle between them. On receive, dibits qualified by the carrier/data-valid line are gathered into bytes. The first dibit lands in bits [1:0] of the byte, and each finished byte is flagged with a single-cycle strobe.

A mode input picks 100 Mbps or 10 Mbps. At 10 Mbps the clock stays at 50 MHz. Instead, each transmitted dibit is held for ten clocks, and each received dibit is sampled once in every ten-clock window.

Top module: `rmii_dibit_adapter`

## Requirements
- R1: After reset, phy_tx_en=0, phy_txd=00, rx_valid=0, rx_error=0 and tx_ready=1.
- R2: With slow_mode=0, an accepted byte appears on phy_txd as four dibits on four consecutive clocks, bits [1:0] first and bits [7:6] last, with phy_tx_en=1 on each of those clocks.
- R3: With slow_mode=1, each dibit of an accepted byte is held unchanged on phy_txd for exactly ten clocks, with phy_tx_en=1, in the same order as R2.
- R4: A byte offered while the last dibit of the previous byte is on the pins is taken at once, so phy_tx_en stays high across the byte boundary with no gap.
- R5: Whenever phy_tx_en is low, phy_txd is 00.
- R6: With slow_mode=0, each clock with phy_crs_dv=1 takes one dibit. After four dibits, rx_byte holds them with the first in [1:0] and the fourth in [7:6], and rx_valid is high for exactly one clock.
- R7: With slow_mode=1, phy_rxd is sampled once per ten-clock window, at count 5, where count 0 is the clock on which phy_crs_dv is first seen high. Values at the other nine counts have no effect.
- R8: If phy_crs_dv falls after a number of dibits that is not a multiple of four, the partial byte is dropped, no rx_valid is raised for it, and rx_error is high for exactly one clock.
- R9: While phy_crs_dv is low, activity on phy_rxd produces neither rx_valid nor rx_error.
- R10: tx_ready is low while a byte is being sent, except on the clock that carries the byte's last dibit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 50 MHz reference clock shared by both directions |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_mode | input | 1 | 1 selects 10 Mbps pacing, 0 selects 100 Mbps |
| tx_byte | input | 8 | Byte offered for transmission |
| tx_valid | input | 1 | tx_byte is valid |
| tx_ready | output | 1 | The adapter takes tx_byte on this clock if tx_valid is high |
| phy_txd | output | 2 | Transmit dibit to the PHY |
| phy_tx_en | output | 1 | High while phy_txd carries frame data |
| phy_rxd | input | 2 | Receive dibit from the PHY |
| phy_crs_dv | input | 1 | Receive qualifier from the PHY |
| rx_byte | output | 8 | Assembled received byte |
| rx_valid | output | 1 | One-clock strobe: rx_byte is new |
| rx_error | output | 1 | One-clock strobe: a partial byte was dropped |

## Verification
In the transmitter, the step that retires a byte's last dibit can fall on the same clock as the load of the next byte. The back-to-back test provokes this by keeping tx_valid high across several bytes in both speed modes. It is judged by a continuous enable with a single frame start, and by a captured dibit stream that matches the expected order with the right hold lengths. On the receive side, the clock on which the qualifier falls is the only one that can end a byte count. Partial frames in both modes check that the drop and the error strobe happen there, with no byte strobe.

// File: rtl/rmii_adapt_pkg.sv
// Shared types and constants for the RMII dibit adapter.
// Assumes a two-bit PHY data path and byte-wide MAC data.
package rmii_adapt_pkg;
    localparam int DIBIT_W = 2;
    typedef logic [DIBIT_W-1:0] dibit_t;
endpackage

// File: rtl/rmii_tx_serializer.sv
// Transmit path: takes a byte over valid/ready and emits it as dibits,
// least significant pair first. In slow mode each dibit is held for
// HOLD_CYCLES clocks. Assumes slow_mode changes only while idle.
module rmii_tx_serializer
    import rmii_adapt_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int HOLD_CYCLES = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_mode,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              tx_valid,
    output logic              tx_ready,
    output dibit_t            phy_txd,
    output logic              phy_tx_en
);
    localparam int DIBITS = BYTE_W / DIBIT_W;
    localparam int IDX_W  = (DIBITS > 1) ? $clog2(DIBITS) : 1;
    localparam int HC_W   = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(DIBITS - 1);
    localparam logic [HC_W-1:0]  HOLD_LAST = HC_W'(HOLD_CYCLES - 1);

    logic              active;
    logic [BYTE_W-1:0] shreg;
    logic [IDX_W-1:0]  idx;
    logic [HC_W-1:0]   hold;
    logic              step;
    logic              last;
    logic              take;

    // Decide when the current dibit is retired and whether a new byte loads.
    always_comb begin
        step     = active && (!slow_mode || hold == HOLD_LAST);
        last     = step && (idx == IDX_LAST);
        tx_ready = !active || last;
        take     = tx_valid && tx_ready;
    end

    // Load, shift and pace the outgoing byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            shreg  <= '0;
            idx    <= '0;
            hold   <= '0;
        end else if (take) begin
            active <= 1'b1;
            shreg  <= tx_byte;
            idx    <= '0;
            hold   <= '0;
        end else if (last) begin
            active <= 1'b0;
            shreg  <= '0;
            idx    <= '0;
            hold   <= '0;
        end else if (step) begin
            shreg  <= shreg >> DIBIT_W;
            idx    <= idx + 1'b1;
            hold   <= '0;
        end else if (active) begin
            hold   <= hold + 1'b1;
        end
    end

    // Drive the pins; zeros between frames.
    always_comb begin
        phy_tx_en = active;
        phy_txd   = active ? shreg[DIBIT_W-1:0] : '0;
    end
endmodule

// File: rtl/rmii_rx_deserializer.sv
// Receive path: gathers qualified dibits into bytes, first dibit in the
// low bits. In slow mode a phase counter started by the qualifier's
// rising edge picks one sample per HOLD_CYCLES window at SAMPLE_AT.
// A qualifier drop mid-byte discards the partial byte and flags it.
module rmii_rx_deserializer
    import rmii_adapt_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int HOLD_CYCLES = 10,
    parameter int SAMPLE_AT   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_mode,
    input  dibit_t            phy_rxd,
    input  logic              phy_crs_dv,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic              rx_error
);
    localparam int DIBITS = BYTE_W / DIBIT_W;
    localparam int IDX_W  = (DIBITS > 1) ? $clog2(DIBITS) : 1;
    localparam int HC_W   = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(DIBITS - 1);
    localparam logic [HC_W-1:0]  HOLD_LAST = HC_W'(HOLD_CYCLES - 1);
    localparam logic [HC_W-1:0]  SAMPLE_V  = HC_W'(SAMPLE_AT);

    logic              crs_q;
    logic [HC_W-1:0]   phase_q;
    logic [HC_W-1:0]   phase_now;
    logic              rise;
    logic              fall;
    logic              sample;
    logic [BYTE_W-1:0] asm_q;
    logic [IDX_W-1:0]  cnt;
    logic [BYTE_W-1:0] asm_next;

    // Edge detection, current window phase and the sample strobe.
    always_comb begin
        rise      = phy_crs_dv && !crs_q;
        fall      = !phy_crs_dv && crs_q;
        phase_now = rise ? '0 : phase_q;
        sample    = phy_crs_dv && (!slow_mode || phase_now == SAMPLE_V);
        asm_next  = {phy_rxd, asm_q[BYTE_W-1:DIBIT_W]};
    end

    // Track the qualifier and the ten-clock window phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crs_q   <= 1'b0;
            phase_q <= '0;
        end else begin
            crs_q   <= phy_crs_dv;
            phase_q <= (phase_now == HOLD_LAST) ? '0 : phase_now + 1'b1;
        end
    end

    // Assemble bytes and raise the completion or drop strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            asm_q    <= '0;
            cnt      <= '0;
            rx_byte  <= '0;
            rx_valid <= 1'b0;
            rx_error <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            rx_error <= 1'b0;
            if (sample) begin
                asm_q <= asm_next;
                if (cnt == IDX_LAST) begin
                    rx_byte  <= asm_next;
                    rx_valid <= 1'b1;
                    cnt      <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else if (fall) begin
                rx_error <= (cnt != '0);
                cnt      <= '0;
            end
        end
    end
endmodule

// File: rtl/rmii_dibit_adapter.sv
// Top level: byte stream to two-bit PHY interface in both directions on
// one reference clock, with 100 Mbps or 10 Mbps pacing by slow_mode.
module rmii_dibit_adapter
    import rmii_adapt_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int HOLD_CYCLES = 10,
    parameter int SAMPLE_AT   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_mode,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic [1:0]        phy_txd,
    output logic              phy_tx_en,
    input  logic [1:0]        phy_rxd,
    input  logic              phy_crs_dv,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic              rx_error
);
    rmii_tx_serializer #(
        .BYTE_W      (BYTE_W),
        .HOLD_CYCLES (HOLD_CYCLES)
    ) i_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_mode (slow_mode),
        .tx_byte   (tx_byte),
        .tx_valid  (tx_valid),
        .tx_ready  (tx_ready),
        .phy_txd   (phy_txd),
        .phy_tx_en (phy_tx_en)
    );

    rmii_rx_deserializer #(
        .BYTE_W      (BYTE_W),
        .HOLD_CYCLES (HOLD_CYCLES),
        .SAMPLE_AT   (SAMPLE_AT)
    ) i_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .slow_mode  (slow_mode),
        .phy_rxd    (phy_rxd),
        .phy_crs_dv (phy_crs_dv),
        .rx_byte    (rx_byte),
        .rx_valid   (rx_valid),
        .rx_error   (rx_error)
    );
endmodule

// File: rtl/rmii_dibit_adapter_chk.sv
// Assertion checker for rmii_dibit_adapter, attached by bind.
// Assumes slow_mode is changed only while the transmitter is idle.
module rmii_dibit_adapter_chk #(
    parameter int HOLD_CYCLES = 10
) (
    input logic       clk,
    input logic       rst_n,
    input logic       slow_mode,
    input logic       tx_ready,
    input logic [1:0] phy_txd,
    input logic       phy_tx_en,
    input logic       rx_valid,
    input logic       rx_error
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);
    logic [CW-1:0] run;

    // Position of the current clock inside a slow-mode dibit hold.
    always_ff @(posedge clk) begin
        if (!rst_n || !phy_tx_en) run <= '0;
        else run <= (run == CW'(HOLD_CYCLES - 1)) ? '0 : run + 1'b1;
    end

    AST_SLOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        slow_mode && phy_tx_en && run != '0 |-> $stable(phy_txd)); // R3
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(phy_tx_en) |-> phy_txd == 2'b00); // R5
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R6
    AST_ERROR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_error |=> !rx_error); // R8
    AST_ERROR_NO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_error |-> !rx_valid); // R8
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_ready |-> phy_tx_en); // R10
endmodule

bind rmii_dibit_adapter rmii_dibit_adapter_chk #(.HOLD_CYCLES(HOLD_CYCLES)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .slow_mode (slow_mode),
    .tx_ready  (tx_ready),
    .phy_txd   (phy_txd),
    .phy_tx_en (phy_tx_en),
    .rx_valid  (rx_valid),
    .rx_error  (rx_error)
);

// File: tb/test_rmii_dibit_adapter.sv
module test_rmii_dibit_adapter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slow_mode = 1'b0;
    logic [7:0] tx_byte = '0;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic [1:0] phy_txd;
    logic       phy_tx_en;
    logic [1:0] phy_rxd = '0;
    logic       phy_crs_dv = 1'b0;
    logic [7:0] rx_byte;
    logic       rx_valid;
    logic       rx_error;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rmii_dibit_adapter i_rmii_dibit_adapter (
        .clk(clk), .rst_n(rst_n), .slow_mode(slow_mode),
        .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .phy_txd(phy_txd), .phy_tx_en(phy_tx_en),
        .phy_rxd(phy_rxd), .phy_crs_dv(phy_crs_dv),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_error(rx_error)
    );

    // Monitors, sampled on the falling edge.
    logic [1:0] tx_cap [0:4095];
    int         tx_n = 0;
    int         tx_frames = 0;
    int         idle_bad = 0;
    bit         en_prev = 1'b0;
    logic [7:0] rx_cap [0:63];
    int         rx_n = 0;
    int         rx_errs = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (phy_tx_en) begin
                if (tx_n < 4096) tx_cap[tx_n] = phy_txd;
                tx_n++;
                if (!en_prev) tx_frames++;
            end else if (phy_txd != 2'b00) begin
                idle_bad++;
            end
            en_prev = phy_tx_en;
            if (rx_valid) begin
                if (rx_n < 64) rx_cap[rx_n] = rx_byte;
                rx_n++;
            end
            if (rx_error) rx_errs++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Offer bytes over the handshake; optionally look at tx_ready after the first take.
    task automatic send_bytes(input logic [7:0] b [4], input int n, input bit see_ready);
        for (int k = 0; k < n; k++) begin
            tx_byte  = b[k];
            tx_valid = 1'b1;
            forever begin
                if (tx_ready) begin
                    @(negedge clk);
                    break;
                end
                @(negedge clk);
            end
            if (see_ready && k == 0)
                chk(tx_ready == 1'b0, "R10 ready low mid-byte", tx_ready, 0);
        end
        tx_valid = 1'b0;
        while (phy_tx_en) @(negedge clk);
        idle(3);
    endtask

    // Compare captured transmit stream against the bytes and hold length.
    task automatic tx_compare(input logic [7:0] b [4], input int n, input int hold,
                              input int base, input string req);
        int bad = 0;
        chk(tx_n - base == n * 4 * hold, {req, " enabled cycles"}, tx_n - base, n * 4 * hold);
        for (int i = 0; i < n * 4 * hold; i++) begin
            int d = i / hold;
            logic [1:0] exp = b[d / 4][(d % 4) * 2 +: 2];
            if (tx_cap[base + i] != exp) bad++;
        end
        chk(bad == 0, {req, " dibit order and hold"}, bad, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        idle(3);
        chk(phy_tx_en == 0 && phy_txd == 0, "R1 tx pins idle", {phy_tx_en, phy_txd}, 0);
        chk(rx_valid == 0 && rx_error == 0, "R1 rx strobes low", {rx_valid, rx_error}, 0);
        chk(tx_ready == 1, "R1 ready", tx_ready, 1);
        rst_n = 1'b1;
        idle(2);
    endtask

    task automatic t_tx_fast();
        logic [7:0] b [4] = '{8'hB4, 8'h00, 8'h00, 8'h00};
        int base = tx_n;
        int f0 = tx_frames;
        slow_mode = 1'b0;
        send_bytes(b, 1, 1'b1);
        tx_compare(b, 1, 1, base, "R2 fast tx");
        chk(tx_frames - f0 == 1, "R2 one enable run", tx_frames - f0, 1);
    endtask

    task automatic t_tx_b2b(input bit slow);
        logic [7:0] b [4] = '{8'h1E, 8'hC3, 8'h6D, 8'h00};
        int base = tx_n;
        int f0 = tx_frames;
        int hold = slow ? 10 : 1;
        slow_mode = slow;
        send_bytes(b, 3, 1'b0);
        tx_compare(b, 3, hold, base, slow ? "R4 b2b slow (R3)" : "R4 b2b fast");
        chk(tx_frames - f0 == 1, "R4 no gap between bytes", tx_frames - f0, 1);
        slow_mode = 1'b0;
    endtask

    task automatic t_tx_slow();
        logic [7:0] b [4] = '{8'h9C, 8'h00, 8'h00, 8'h00};
        int base = tx_n;
        slow_mode = 1'b1;
        send_bytes(b, 1, 1'b1);
        tx_compare(b, 1, 10, base, "R3 slow tx");
        slow_mode = 1'b0;
    endtask

    // Drive dibits; in slow mode garbage is placed at every count except 5.
    task automatic rx_drive(input logic [1:0] d [16], input int n, input bit slow, input bit garble);
        slow_mode = slow;
        for (int i = 0; i < n; i++) begin
            for (int c = 0; c < (slow ? 10 : 1); c++) begin
                phy_crs_dv = 1'b1;
                phy_rxd = (garble && c != 5) ? ~d[i] : d[i];
                @(negedge clk);
            end
        end
        phy_crs_dv = 1'b0;
        phy_rxd = 2'b00;
        idle(4);
        slow_mode = 1'b0;
    endtask

    task automatic t_rx(input logic [7:0] b0, input logic [7:0] b1, input int nbytes,
                        input bit slow, input bit garble, input string req);
        logic [1:0] d [16];
        int r0 = rx_n;
        int e0 = rx_errs;
        for (int i = 0; i < 4; i++) begin
            d[i] = b0[i*2 +: 2];
            d[i+4] = b1[i*2 +: 2];
        end
        for (int i = 8; i < 16; i++) d[i] = 2'b00;
        rx_drive(d, nbytes * 4, slow, garble);
        chk(rx_n - r0 == nbytes, {req, " byte count"}, rx_n - r0, nbytes);
        if (rx_n - r0 >= 1) chk(rx_cap[r0] == b0, {req, " first byte"}, rx_cap[r0], b0);
        if (nbytes == 2 && rx_n - r0 >= 2) chk(rx_cap[r0+1] == b1, {req, " second byte"}, rx_cap[r0+1], b1);
        chk(rx_errs == e0, {req, " no error"}, rx_errs - e0, 0);
    endtask

    task automatic t_rx_partial(input bit slow);
        logic [1:0] d [16];
        int r0 = rx_n;
        int e0 = rx_errs;
        logic [7:0] b = 8'h72;
        for (int i = 0; i < 4; i++) d[i] = b[i*2 +: 2];
        for (int i = 4; i < 16; i++) d[i] = 2'b11;
        rx_drive(d, 6, slow, 1'b0);
        chk(rx_n - r0 == 1, "R8 only whole byte delivered", rx_n - r0, 1);
        if (rx_n - r0 >= 1) chk(rx_cap[r0] == b, "R8 whole byte value", rx_cap[r0], b);
        chk(rx_errs - e0 == 1, "R8 one error pulse", rx_errs - e0, 1);
    endtask

    task automatic t_rx_ignored();
        int r0 = rx_n;
        int e0 = rx_errs;
        phy_crs_dv = 1'b0;
        for (int i = 0; i < 20; i++) begin
            phy_rxd = 2'(i);
            @(negedge clk);
        end
        phy_rxd = 2'b00;
        idle(3);
        chk(rx_n == r0 && rx_errs == e0, "R9 no strobe without qualifier",
            (rx_n - r0) + (rx_errs - e0), 0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_tx_fast();
        t_tx_slow();
        t_tx_b2b(1'b0);
        t_tx_b2b(1'b1);
        chk(idle_bad == 0, "R5 idle pins zero", idle_bad, 0);
        t_rx(8'hA5, 8'h3C, 2, 1'b0, 1'b0, "R6 fast rx");
        t_rx(8'h96, 8'h00, 1, 1'b1, 1'b0, "R7 slow rx");
        t_rx(8'h5A, 8'h00, 1, 1'b1, 1'b1, "R7 sample at count 5");
        t_rx_partial(1'b0);
        t_rx_partial(1'b1);
        t_rx_ignored();
        done = 1'b1;
        finish_run();
    end
endmodule